// File: doc/BRIEF.md
# Full-Adder Tree Ones Counter

This block reports how many bits of an input word are set. The word is 8 bits wide by default, or 7 bits when a parameter selects the narrow variant. The count comes out as a 4-bit unsigned number.

The arithmetic is built only from a one-bit full-adder cell, instantiated explicitly. A first rank of cells compresses the word into 2-bit partial counts. Small ripple adders, also made of the same cell, then merge those partial counts. No generic adder, table or counting loop appears in the datapath.

In the 7-bit variant the seventh input bit drives the carry-in of the ripple adder that merges the two partial counts. The third first-rank cell and the final adder are therefore not built. A parameter can place an output register behind the tree; the register has an asynchronous active-low reset. With the register removed, the block is purely combinational.

Top module: `ones_count_top`

## Requirements
- R1: `count_out` equals the number of set bits in the applied word, for every input value.
- R2: An input word with no bits set gives a count of 0.
- R3: An input word with all bits set gives a count equal to the word width: 8 by default, 7 in the narrow variant.
- R4: Whenever the input is known, every bit of `count_out` is known, including the carries of adder positions that can never be set.
- R5: The count never exceeds the word width.
- R6: With `REG_OUT`=1, `count_out` reflects the input sampled at the previous rising clock edge, so the latency is one cycle. With `REG_OUT`=0, it follows the input combinationally.
- R7: While `rst_n` is low, the registered `count_out` is 0, and it clears immediately, without waiting for a clock edge.
- R8: With `WORD_W`=7, bit 3 of `count_out` is always 0 and bit 6 of the input is counted through the merging adder's carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| data_in | input | WORD_W | Word whose set bits are counted |
| count_out | output | 4 | Number of set bits, unsigned |

## Verification
A miswired or stuck cell in the tree produces a wrong count only for the input patterns that reach that cell. The count is wrong either in the same cycle (combinational variant) or exactly one clock later (registered variant). For this reason every one of the 256 words is applied and compared against a behavioural count. A stuck high-order carry shows up first at the words with many bits set, such as all ones. A broken reset or a missing register shows up as a count that appears one cycle early or does not clear at once.

// File: rtl/ones_count_pkg.sv
package ones_count_pkg;
  localparam int unsigned CNT_W = 4;
  typedef logic [CNT_W-1:0] count_t;
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = a ^ b ^ ci;
    co = (a & b) | (a & ci) | (b & ci);
  end
endmodule

// File: rtl/ripple_add.sv
module ripple_add #(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] carry;

  assign carry[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_bit
    fa_cell u_fa (
      .a (a[i]),
      .b (b[i]),
      .ci(carry[i]),
      .s (s[i]),
      .co(carry[i+1])
    );
  end

  assign co = carry[W];
endmodule

// File: rtl/ones_tree.sv
module ones_tree
  import ones_count_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic [WORD_W-1:0] word,
  output count_t            cnt
);
  // first rank: two 3:2 compressors on bits 0..5
  logic [1:0] part_lo, part_mid;
  logic [1:0] pair_s;
  logic       pair_co;

  fa_cell u_c0 (.a(word[0]), .b(word[1]), .ci(word[2]),
                .s(part_lo[0]), .co(part_lo[1]));
  fa_cell u_c1 (.a(word[3]), .b(word[4]), .ci(word[5]),
                .s(part_mid[0]), .co(part_mid[1]));

  if (WORD_W == 7) begin : g_narrow
    // bit 6 enters as carry-in of the merging adder
    ripple_add #(.W(2)) u_pair (
      .a (part_lo),
      .b (part_mid),
      .ci(word[6]),
      .s (pair_s),
      .co(pair_co)
    );
    assign cnt = {1'b0, pair_co, pair_s};
  end else begin : g_wide
    logic [1:0] part_hi;
    logic [2:0] fin_s;
    logic       fin_co;

    fa_cell u_c2 (.a(word[6]), .b(word[7]), .ci(1'b0),
                  .s(part_hi[0]), .co(part_hi[1]));

    ripple_add #(.W(2)) u_pair (
      .a (part_lo),
      .b (part_mid),
      .ci(1'b0),
      .s (pair_s),
      .co(pair_co)
    );

    ripple_add #(.W(3)) u_fin (
      .a ({pair_co, pair_s}),
      .b ({1'b0, part_hi}),
      .ci(1'b0),
      .s (fin_s),
      .co(fin_co)
    );
    assign cnt = {fin_co, fin_s};
  end

  always_comb begin
    if (!$isunknown(word)) begin
      AST_NO_OVERFLOW: assert (cnt <= count_t'(WORD_W)); // R5
      AST_KNOWN_COUNT: assert (!$isunknown(cnt)); // R4
      AST_EXACT_COUNT: assert (cnt == count_t'($countones(word))); // R1
      if (word == '0) begin
        AST_EMPTY_ZERO: assert (cnt == '0); // R2
      end
      if (&word) begin
        AST_FULL_WIDTH: assert (cnt == count_t'(WORD_W)); // R3
      end
      if (WORD_W == 7) begin
        AST_NARROW_TOP: assert (cnt[CNT_W-1] == 1'b0); // R8
      end
    end
  end
endmodule

// File: rtl/ones_count_top.sv
module ones_count_top
  import ones_count_pkg::*;
#(
  parameter int unsigned WORD_W  = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] data_in,
  output logic [CNT_W-1:0]  count_out
);
  count_t tree_cnt;

  ones_tree #(.WORD_W(WORD_W)) u_tree (
    .word(data_in),
    .cnt (tree_cnt)
  );

  if (REG_OUT) begin : g_reg
    count_t cnt_d, cnt_q;
    logic   cnt_en;

    always_comb begin
      cnt_en = 1'b1;
      cnt_d  = tree_cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign count_out = cnt_q;

    AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |-> count_out == '0); // R7
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$isunknown($past(data_in))
        |-> count_out == count_t'($countones($past(data_in)))); // R6
    AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$isunknown($past(data_in)) |-> !$isunknown(count_out)); // R4
  end else begin : g_comb
    assign count_out = tree_cnt;
  end
endmodule

// File: tb/ones_count_top_test.sv
module ones_count_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] din8;
  logic [6:0] din7;
  logic [3:0] cnt8, cnt7;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int cycles = 0;

  always #4 clk = ~clk;

  ones_count_top #(.WORD_W(8), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .data_in(din8), .count_out(cnt8));

  ones_count_top #(.WORD_W(7), .REG_OUT(1'b0)) uut7 (
    .clk(clk), .rst_n(rst_n), .data_in(din7), .count_out(cnt7));

  function automatic int ref_ones(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) if (v[i] === 1'b1) n++;
    return n;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input int exp);
    checks++;
    if (act !== 4'(exp)) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // drive on negedge, 7-bit comb check right away, 8-bit registered check next negedge
  task automatic apply(input logic [7:0] v, inout int prev, input string tag);
    @(negedge clk);
    din8 = v;
    din7 = v[6:0];
    #1;
    check("R1/R6 registered holds prior value", cnt8, prev);
    check("R1/R6 narrow comb follows input", cnt7, ref_ones({1'b0, v[6:0]}));
    check("R8 narrow top bit", {3'b0, cnt7[3]}, 0);
    prev = ref_ones(v);
  endtask

  initial begin
    int prev;
    rst_n = 1'b0;
    din8  = 8'hFF;
    din7  = 7'h7F;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 reset holds zero", cnt8, 0);
    check("R3 narrow all ones", cnt7, 7);
    rst_n = 1'b1;
    din8  = 8'h00;
    din7  = 7'h00;
    prev  = 0;
    @(posedge clk);
    #1;
    check("R2 zero word", cnt8, 0);
    check("R2 narrow zero word", cnt7, 0);
    for (int v = 0; v < 256; v++) apply(8'(v), prev, "sweep");
    for (int k = 0; k < 8; k++) apply(8'(1) << k, prev, "walk1");
    for (int k = 0; k < 8; k++) apply(~(8'(1) << k), prev, "walk0");
    apply(8'hFF, prev, "full");
    apply(8'h00, prev, "empty");
    check("R3 all ones gives 8", cnt8, 8);
    apply(8'hFF, prev, "full");
    check("R2 zero word registered", cnt8, 0);
    @(negedge clk);
    check("R3 all ones registered", cnt8, 8);
    check("R5 range", {3'b0, (cnt8 > 4'd8)}, 0);
    check("R4 known output", {3'b0, $isunknown(cnt8)}, 0);
    #1 rst_n = 1'b0;
    #1;
    check("R7 async clear", cnt8, 0);
    @(negedge clk);
    rst_n = 1'b1;
    check("R7 still zero before edge", cnt8, 0);
    @(negedge clk);
    check("R6 capture after reset", cnt8, 8);
    finish_run();
  end
endmodule